// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement Credit

This block decides when a DRAM controller must issue REFRESH commands. A free-running interval timer adds one refresh to a pending-credit counter at the end of every refresh interval. While credit is available and the device is neither refreshing nor in self refresh, the block raises a request. The controller answers with a grant in the cycle in which it places the REFRESH command on the bus. Each accepted grant consumes one credit and holds the command bus blocked for the refresh recovery time.

The controller may postpone refreshes while it is busy with traffic, up to a credit limit of eight. When the pending count reaches that limit, an urgent flag tells the controller to refresh without further delay. An extended-temperature input halves the interval. A self-refresh input freezes the interval timer and suppresses requests, and the pending credit is kept unchanged so that it still counts toward the same limit after exit. REFRESH carries no address, so the block produces none.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ref_req_o`, `ref_urgent_o` and `bus_block_o` are 0 and `pend_cnt_o` is 0.
- R2: With `hot_i` = 0 and no self refresh, the first pending refresh appears exactly `REFI_CYC` rising edges after reset is released, and one more is added every `REFI_CYC` edges after that.
- R3: With `hot_i` = 1, the interval becomes `REFI_CYC/2` edges.
- R4: `ref_req_o` is 1 exactly when the pending count is nonzero, no refresh recovery is in progress and self refresh is not active; it is never 1 together with `bus_block_o`.
- R5: A grant (`ref_grant_i` = 1 at a rising edge while `ref_req_o` = 1) lowers the pending count by one at that edge (unless an interval ends at the same edge) and raises `bus_block_o` for exactly `RFC_CYC` cycles after it.
- R6: `ref_urgent_o` is 1 exactly when the pending count equals `MAX_PEND` (8), and falls at the edge of the grant that lowers the count.
- R7: The pending count never exceeds `MAX_PEND`; an interval that ends with the count already at the limit leaves it at the limit.
- R8: While `sr_active_i` is 1 the interval timer does not advance, `ref_req_o` is 0 from the next edge on, and the pending count is retained; after exit, counting resumes from the frozen position.
- R9: `ref_grant_i` has no effect while `ref_req_o` is 0, including during refresh recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | Extended temperature range: halves the refresh interval |
| sr_active_i | input | 1 | Device is in self refresh |
| ref_grant_i | input | 1 | Controller issues REFRESH in this cycle |
| ref_req_o | output | 1 | A refresh is wanted |
| ref_urgent_o | output | 1 | Postponement credit exhausted; refresh now |
| bus_block_o | output | 1 | Refresh recovery in progress; command bus is blocked |
| pend_cnt_o | output | PEND_W | Number of postponed refreshes |

## Verification
The hardest state to reach is a full credit counter meeting an interval boundary: it takes eight whole intervals without a single grant, and then one more to show saturation. The bench withholds grants for nine intervals from reset, samples on the exact edge of each boundary, and grants one cycle after a boundary so that the decrement cannot coincide with a new tick. Self refresh is entered on the cycle the first credit appears, which fixes the frozen timer position and makes the tick after exit predictable to the cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic {TEMP_NORMAL = 1'b0, TEMP_EXTENDED = 1'b1} temp_range_e;

  function automatic int unsigned interval_for(input int unsigned base, input temp_range_e t);
    return (t == TEMP_EXTENDED) ? base / 2 : base;
  endfunction
endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int unsigned REFI_CYC = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic hot_i,
  input  logic freeze_i,
  output logic tick_o
);
  import refsched_pkg::*;
  localparam int unsigned CNT_W = $clog2(REFI_CYC + 1);
  localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'(interval_for(REFI_CYC, TEMP_NORMAL) - 1);
  localparam logic [CNT_W-1:0] LIM_HOT  = CNT_W'(interval_for(REFI_CYC, TEMP_EXTENDED) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = hot_i ? LIM_HOT : LIM_NORM;
  assign tick_o   = !freeze_i && (cnt_q >= last_val);

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (freeze_i)   cnt_q <= cnt_q;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assert_frozen_in_sr_R8: assert property (@(posedge clk) disable iff (rst)
    freeze_i |=> $stable(cnt_q));
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_NORM);
endmodule

// File: rtl/rfc_timer.sv
module rfc_timer #(
  parameter int unsigned RFC_CYC = 52
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_next_o,
  output logic busy_o
);
  localparam int unsigned RC_W = $clog2(RFC_CYC + 1);
  localparam logic [RC_W-1:0] RFC_LOAD = RC_W'(RFC_CYC);

  logic [RC_W-1:0] rc_q, rc_d;

  always_comb begin
    if (start_i)          rc_d = RFC_LOAD;
    else if (rc_q != '0)  rc_d = rc_q - 1'b1;
    else                  rc_d = '0;
  end

  assign busy_next_o = (rc_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_q   <= '0;
      busy_o <= 1'b0;
    end else begin
      rc_q   <= rc_d;
      busy_o <= busy_next_o;
    end
  end

  assert_block_after_grant_R5: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);
  assert_no_restart_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !start_i);
endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              take_i,
  output logic [PEND_W-1:0] pend_o,
  output logic [PEND_W-1:0] pend_next_o,
  output logic              full_o
);
  localparam logic [PEND_W-1:0] CAP = PEND_W'(MAX_PEND);

  always_comb begin
    pend_next_o = pend_o;
    if (tick_i && !take_i) begin
      if (pend_o != CAP) pend_next_o = pend_o + 1'b1;
    end else if (take_i && !tick_i) begin
      pend_next_o = pend_o - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      full_o <= 1'b0;
    end else begin
      pend_o <= pend_next_o;
      full_o <= (pend_next_o == CAP);
    end
  end

  assert_pend_cap_R7: assert property (@(posedge clk) disable iff (rst)
    pend_o <= CAP);
  assert_urgent_matches_full_R6: assert property (@(posedge clk) disable iff (rst)
    full_o == (pend_o == CAP));
  assert_no_take_when_empty_R5: assert property (@(posedge clk) disable iff (rst)
    take_i |-> pend_o != '0);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned REFI_CYC = 1560,
  parameter int unsigned RFC_CYC  = 52,
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned PEND_W  = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hot_i,
  input  logic              sr_active_i,
  input  logic              ref_grant_i,
  output logic              ref_req_o,
  output logic              ref_urgent_o,
  output logic              bus_block_o,
  output logic [PEND_W-1:0] pend_cnt_o
);
  logic tick, accept, busy_next;
  logic [PEND_W-1:0] pend_next;

  assign accept = ref_grant_i && ref_req_o;

  refi_timer #(.REFI_CYC(REFI_CYC)) u_refi (
    .clk(clk), .rst(rst), .hot_i(hot_i), .freeze_i(sr_active_i), .tick_o(tick)
  );

  rfc_timer #(.RFC_CYC(RFC_CYC)) u_rfc (
    .clk(clk), .rst(rst), .start_i(accept), .busy_next_o(busy_next), .busy_o(bus_block_o)
  );

  credit_ctr #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_credit (
    .clk(clk), .rst(rst), .tick_i(tick), .take_i(accept),
    .pend_o(pend_cnt_o), .pend_next_o(pend_next), .full_o(ref_urgent_o)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_req_o <= 1'b0;
    else     ref_req_o <= (pend_next != '0) && !busy_next && !sr_active_i;
  end

  assert_req_excl_block_R4: assert property (@(posedge clk) disable iff (rst)
    !(ref_req_o && bus_block_o));
  assert_req_drops_in_sr_R8: assert property (@(posedge clk) disable iff (rst)
    sr_active_i |=> !ref_req_o);
  assert_grant_consumes_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !tick) |=> pend_cnt_o == $past(pend_cnt_o) - 1'b1);
  assert_idle_grant_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (!ref_req_o && !tick) |=> pend_cnt_o == $past(pend_cnt_o));
endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int unsigned REFI = 40;
  localparam int unsigned RFC  = 6;
  localparam int unsigned MAXP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hot = 1'b0, sr = 1'b0, grant = 1'b0;
  logic req, urgent, block;
  logic [3:0] pend;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(.REFI_CYC(REFI), .RFC_CYC(RFC), .MAX_PEND(MAXP)) i_refresh_sched (
    .clk(clk), .rst(rst), .hot_i(hot), .sr_active_i(sr), .ref_grant_i(grant),
    .ref_req_o(req), .ref_urgent_o(urgent), .bus_block_o(block), .pend_cnt_o(pend)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic temp);
    @(negedge clk);
    rst = 1'b1; grant = 1'b0; sr = 1'b0; hot = temp;
    edges(3);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; edges(2);
    chk("R1 req in reset", req, 0);
    chk("R1 block in reset", block, 0);
    rst = 1'b0; edges(1);
    chk("R1 pend after reset", pend, 0);
    chk("R1 urgent after reset", urgent, 0);
  endtask

  task automatic t_interval;
    do_reset(1'b0);
    edges(REFI - 1);
    chk("R2 pend before interval", pend, 0);
    chk("R4 no req without credit", req, 0);
    edges(1);
    chk("R2 pend at interval", pend, 1);
    chk("R4 req with credit", req, 1);
    edges(REFI - 1);
    chk("R2 pend before 2nd interval", pend, 1);
    edges(1);
    chk("R2 pend at 2nd interval", pend, 2);
  endtask

  task automatic t_hot;
    do_reset(1'b1);
    edges(REFI/2 - 1);
    chk("R3 pend before half interval", pend, 0);
    edges(1);
    chk("R3 pend at half interval", pend, 1);
    hot = 1'b0;
  endtask

  task automatic t_idle_grant;
    do_reset(1'b0);
    grant = 1'b1;
    edges(5);
    chk("R9 pend with grant and no req", pend, 0);
    chk("R9 block with grant and no req", block, 0);
    grant = 1'b0;
  endtask

  task automatic t_grant;
    do_reset(1'b0);
    edges(REFI);
    chk("R4 req up", req, 1);
    grant = 1'b1; edges(1); grant = 1'b0;
    chk("R5 pend after grant", pend, 0);
    chk("R5 block after grant", block, 1);
    chk("R4 req low in recovery", req, 0);
    edges(RFC - 1);
    chk("R5 block last cycle", block, 1);
    edges(1);
    chk("R5 block ends", block, 0);
    chk("R4 req stays low without credit", req, 0);
  endtask

  task automatic t_urgent;
    do_reset(1'b0);
    edges(MAXP*REFI - 1);
    chk("R6 pend one below limit", pend, MAXP - 1);
    chk("R6 not urgent below limit", urgent, 0);
    edges(1);
    chk("R6 pend at limit", pend, MAXP);
    chk("R6 urgent at limit", urgent, 1);
    edges(REFI);
    chk("R7 pend saturates", pend, MAXP);
    chk("R7 urgent holds", urgent, 1);
    grant = 1'b1; edges(1);
    chk("R6 pend after grant", pend, MAXP - 1);
    chk("R6 urgent drops", urgent, 0);
    edges(RFC - 1);
    chk("R9 grants in recovery ignored", pend, MAXP - 1);
    chk("R9 block held", block, 1);
    grant = 1'b0; edges(1);
    chk("R5 block released", block, 0);
    chk("R4 req back", req, 1);
  endtask

  task automatic t_selfref;
    do_reset(1'b0);
    edges(REFI);
    chk("R8 credit before entry", pend, 1);
    sr = 1'b1; edges(1);
    chk("R8 req low in sr", req, 0);
    edges(3*REFI);
    chk("R8 credit kept in sr", pend, 1);
    chk("R8 no req in sr", req, 0);
    sr = 1'b0; edges(1);
    chk("R8 req after exit", req, 1);
    edges(REFI - 2);
    chk("R8 no tick before resume", pend, 1);
    edges(1);
    chk("R8 tick after resume", pend, 2);
  endtask

  initial begin
    edges(4);
    t_reset();
    t_interval();
    t_hot();
    t_idle_grant();
    t_grant();
    t_urgent();
    t_selfref();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule